// File: doc/BRIEF.md
# Dual-Rate Output Register Cell

This cell sits between core logic and a pad driver. It registers two signals on their way out: the data bit and the high-impedance control. Each of the two paths is either single-rate, with one bit per clock period, or double-rate. In double-rate mode two core bits taken in on one rising edge leave the cell one after the other, one in each half of the clock period.

The cell clock is one of four sources, with optional inversion. Mode, storage type, clock source and inversion are static settings. The cell takes them in only while reset is held. In single-rate mode the storage element is either an edge-triggered flop or a latch that is open while the cell clock is high.

In double-rate mode a rising edge stores both bits. The rise bit then passes a latch that is open while the cell clock is low, so it holds steady while it is on the output. The cell clock itself drives the output multiplexer.

Top module: `ddr_out_cell`

## Requirements
- R1: While `rst` is high, every register and latch in the cell clears. Both `dat_out` and `hiz_out` read 0 in both clock phases, which means data low and driver enabled, whatever the inputs are.
- R2: Single-rate flop mode (`cfg_ddr`=0, `cfg_latch`=0): each output equals its rise input as it was at the latest rising cell-clock edge, and holds for the full period. An input change between edges does not reach the output.
- R3: Single-rate latch mode (`cfg_ddr`=0, `cfg_latch`=1): each output follows its rise input while the cell clock is high. It holds the value present at the falling edge while the cell clock is low.
- R4: Double-rate mode (`cfg_ddr`=1): take the rise and fall inputs stored at rising edge k. The rise bit drives the output in the high phase after edge k+1, and the fall bit drives it in the low phase after edge k+1.
- R5: The high-impedance path (`hiz_rise`, `hiz_fall` to `hiz_out`) behaves exactly like the data path in every mode.
- R6: `cfg_src` picks the cell clock. 0 selects `clk_fabric`, 1 selects `clk_edge_a`, 2 selects `clk_edge_b` and 3 selects `clk_strobe`. Activity on the unselected sources has no effect on the outputs.
- R7: With `cfg_inv`=1 the cell clock is the inverse of the selected source. All edges and phases in R2 to R4 then refer to the inverted clock.
- R8: The cell takes in the configuration inputs only while `rst` is high. Changing them while `rst` is low leaves the running behaviour unchanged.
- R9: In double-rate mode, both phases of the first clock period after reset release output 0 on each path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fabric | input | 1 | Clock source 0, from general routing |
| clk_edge_a | input | 1 | Clock source 1, edge clock A |
| clk_edge_b | input | 1 | Clock source 2, edge clock B |
| clk_strobe | input | 1 | Clock source 3, strobe clock |
| rst | input | 1 | Active-high reset; also opens configuration capture |
| cfg_ddr | input | 1 | 1 selects double-rate mode, 0 single-rate |
| cfg_latch | input | 1 | Single-rate storage: 1 latch, 0 flop |
| cfg_src | input | 2 | Clock source select |
| cfg_inv | input | 1 | 1 inverts the selected clock |
| dat_rise | input | 1 | Data bit for the high phase (the only data bit in single-rate mode) |
| dat_fall | input | 1 | Data bit for the low phase |
| hiz_rise | input | 1 | High-impedance control for the high phase |
| hiz_fall | input | 1 | High-impedance control for the low phase |
| dat_out | output | 1 | Serialized data to the pad driver |
| hiz_out | output | 1 | Serialized high-impedance control (1 = driver off) |

## Verification
Eight bit patterns of rise and fall data are played through all 32 configuration combinations, with both phases of every period sampled. The patterns include alternating, constant and runs of equal bits, and the rise and fall streams differ. This shows whether the double-rate output has the right phase order and the one-period delay, and it separates these from the single-rate behaviour. Clock sources that are not selected toggle at unrelated rates, so a wrong source or a missing inversion shows up as mistimed bits. Directed cases then do four things:
- Change the input in the middle of a phase, which tells the latch apart from the flop.
- Change the configuration pins while the cell runs.
- Assert reset in the middle of a stream.
- Check the zero output in the first double-rate period after reset.

// File: rtl/ddro_pkg.sv
package ddro_pkg;

  typedef enum logic [1:0] {
    SRC_FABRIC = 2'd0,
    SRC_EDGE_A = 2'd1,
    SRC_EDGE_B = 2'd2,
    SRC_STROBE = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic     ddr;
    logic     latch;
    clk_src_e src;
    logic     inv;
  } cell_cfg_t;

endpackage

// File: rtl/ddro_cfg_hold.sv
module ddro_cfg_hold
  import ddro_pkg::*;
(
  input  logic      cclk,
  input  logic      rst,
  input  cell_cfg_t cfg_in,
  output cell_cfg_t cfg_q
);

  // Configuration is transparent only while reset is held.
  always_latch begin
    if (rst) cfg_q <= cfg_in;
  end

  // R8
  cfg_frozen_chk: assert property (@(posedge cclk) disable iff (rst)
    !rst |=> $stable(cfg_q));

endmodule

// File: rtl/ddro_clk_pick.sv
module ddro_clk_pick #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] srcs,
  input  logic [SEL_W-1:0]   sel,
  input  logic               inv,
  output logic               cclk
);

  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) picked = srcs[i];
    end
  end

  assign cclk = picked ^ inv;

endmodule

// File: rtl/ddro_lane.sv
module ddro_lane (
  input  logic cclk,
  input  logic rst,
  input  logic ddr_en,
  input  logic latch_en,
  input  logic d_rise,
  input  logic d_fall,
  output logic q
);

  logic rise_r;     // rising-edge capture of rise bit (also SDR flop)
  logic fall_r;     // rising-edge capture of fall bit
  logic fall_r2;    // fall bit retimed one more period
  logic rise_hold;  // rise bit retimed through low-phase latch
  logic sdr_lat;    // SDR latch, open while clock high

  always_ff @(posedge cclk) begin
    if (rst) begin
      rise_r  <= 1'b0;
      fall_r  <= 1'b0;
      fall_r2 <= 1'b0;
    end else begin
      rise_r  <= d_rise;
      fall_r  <= d_fall;
      fall_r2 <= fall_r;
    end
  end

  always_latch begin
    if (rst)        rise_hold <= 1'b0;
    else if (!cclk) rise_hold <= rise_r;
  end

  always_latch begin
    if (rst)       sdr_lat <= 1'b0;
    else if (cclk) sdr_lat <= d_rise;
  end

  always_comb begin
    if (ddr_en)        q = cclk ? rise_hold : fall_r2;
    else if (latch_en) q = sdr_lat;
    else               q = rise_r;
  end

  // R2
  sdr_flop_track_chk: assert property (@(posedge cclk) disable iff (rst)
    (!ddr_en && !latch_en) |=> (q == $past(d_rise)));

  // R3
  sdr_latch_close_chk: assert property (@(negedge cclk) disable iff (rst)
    (!ddr_en && latch_en) |-> (q == d_rise));

  // R4
  ddr_fall_delay_chk: assert property (@(posedge cclk) disable iff (rst)
    (ddr_en ##1 !rst) |=> (fall_r2 == $past(d_fall, 2)));

endmodule

// File: rtl/ddr_out_cell.sv
module ddr_out_cell
  import ddro_pkg::*;
(
  input  logic       clk_fabric,
  input  logic       clk_edge_a,
  input  logic       clk_edge_b,
  input  logic       clk_strobe,
  input  logic       rst,
  input  logic       cfg_ddr,
  input  logic       cfg_latch,
  input  logic [1:0] cfg_src,
  input  logic       cfg_inv,
  input  logic       dat_rise,
  input  logic       dat_fall,
  input  logic       hiz_rise,
  input  logic       hiz_fall,
  output logic       dat_out,
  output logic       hiz_out
);

  localparam int NUM_SRC = 4;
  localparam int LANES   = 2;   // lane 0 data, lane 1 high-impedance control

  cell_cfg_t          cfg_in, cfg_q;
  logic               cclk;
  logic [NUM_SRC-1:0] srcs;
  logic [LANES-1:0]   rise_v, fall_v, out_v;

  assign cfg_in = '{ddr: cfg_ddr, latch: cfg_latch,
                    src: clk_src_e'(cfg_src), inv: cfg_inv};
  assign srcs   = {clk_strobe, clk_edge_b, clk_edge_a, clk_fabric};
  assign rise_v = {hiz_rise, dat_rise};
  assign fall_v = {hiz_fall, dat_fall};

  ddro_cfg_hold u_cfg (
    .cclk   (cclk),
    .rst    (rst),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  ddro_clk_pick #(.NUM_SRC(NUM_SRC)) u_clk (
    .srcs (srcs),
    .sel  (cfg_q.src),
    .inv  (cfg_q.inv),
    .cclk (cclk)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddro_lane u_lane (
      .cclk     (cclk),
      .rst      (rst),
      .ddr_en   (cfg_q.ddr),
      .latch_en (cfg_q.latch),
      .d_rise   (rise_v[g]),
      .d_fall   (fall_v[g]),
      .q        (out_v[g])
    );
  end

  assign dat_out = out_v[0];
  assign hiz_out = out_v[1];

  // R1
  reset_clear_chk: assert property (@(posedge cclk) disable iff (rst)
    $fell(rst) |-> (!dat_out && !hiz_out));

endmodule

// File: tb/ddr_out_cell_tb.sv
module ddr_out_cell_tb;

  logic tb_clk = 1'b0;
  logic n0 = 1'b0, n1 = 1'b0, n2 = 1'b0, n3 = 1'b0;
  always #10 tb_clk = ~tb_clk;   // 50 MHz
  always #3  n0 = ~n0;
  always #7  n1 = ~n1;
  always #13 n2 = ~n2;
  always #5  n3 = ~n3;

  logic [1:0] run_src = 2'd0;
  logic       run_inv = 1'b0;
  logic       eff;
  assign eff = tb_clk ^ run_inv;

  logic       c_fab, c_ea, c_eb, c_st;
  assign c_fab = (run_src == 2'd0) ? tb_clk : n0;
  assign c_ea  = (run_src == 2'd1) ? tb_clk : n1;
  assign c_eb  = (run_src == 2'd2) ? tb_clk : n2;
  assign c_st  = (run_src == 2'd3) ? tb_clk : n3;

  logic       rst = 1'b1;
  logic       cfg_ddr = 1'b0, cfg_latch = 1'b0, cfg_inv = 1'b0;
  logic [1:0] cfg_src = 2'd0;
  logic       dat_rise = 1'b0, dat_fall = 1'b0, hiz_rise = 1'b0, hiz_fall = 1'b0;
  logic       dat_out, hiz_out;

  ddr_out_cell u_dut (
    .clk_fabric (c_fab),
    .clk_edge_a (c_ea),
    .clk_edge_b (c_eb),
    .clk_strobe (c_st),
    .rst        (rst),
    .cfg_ddr    (cfg_ddr),
    .cfg_latch  (cfg_latch),
    .cfg_src    (cfg_src),
    .cfg_inv    (cfg_inv),
    .dat_rise   (dat_rise),
    .dat_fall   (dat_fall),
    .hiz_rise   (hiz_rise),
    .hiz_fall   (hiz_fall),
    .dat_out    (dat_out),
    .hiz_out    (hiz_out)
  );

  // Stimulus rows: [31:24] dat_rise, [23:16] dat_fall,
  // [15:8] hiz_rise, [7:0] hiz_fall; bit c used in cycle c.
  localparam logic [31:0] PAT [8] = '{
    32'hAA55_F00F,
    32'h55AA_0FF0,
    32'hFF00_3C3C,
    32'h00FF_C3C3,
    32'hCC33_9696,
    32'h0F0F_6969,
    32'hE718_FFFF,
    32'h1BE4_0000
  };

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  task automatic check(string req, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  // Reset with a new configuration; inputs held at 1 to show clearing.
  // Returns 16 ns after a rising cell-clock edge, reset released.
  task automatic setup(logic ddr, logic lat, logic [1:0] src, logic inv);
    rst = 1'b1;
    cfg_ddr = ddr; cfg_latch = lat; cfg_src = src; cfg_inv = inv;
    run_src = src; run_inv = inv;
    {dat_rise, dat_fall, hiz_rise, hiz_fall} = 4'hF;
    repeat (3) @(posedge eff);
    #5;
    check("R1", "dat_out high phase in reset", dat_out, 1'b0);
    check("R1", "hiz_out high phase in reset", hiz_out, 1'b0);
    #10;
    check("R1", "dat_out low phase in reset", dat_out, 1'b0);
    check("R1", "hiz_out low phase in reset", hiz_out, 1'b0);
    #1;
    rst = 1'b0;
  endtask

  task automatic cycle(logic a, logic b, logic c, logic d,
                       output logic dh, output logic dl,
                       output logic th, output logic tl);
    dat_rise = a; dat_fall = b; hiz_rise = c; hiz_fall = d;
    @(posedge eff);
    #5;
    dh = dat_out; th = hiz_out;
    #10;
    dl = dat_out; tl = hiz_out;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic dh, dl, th, tl;
    // ---------------- table walk over every configuration ----------------
    for (int cf = 0; cf < 32; cf++) begin
      logic ddr, lat, inv;
      logic [1:0] src;
      logic pa, pb, pc, pd;
      ddr = cf[0]; lat = cf[1]; src = 2'(cf >> 2); inv = cf[4];
      setup(ddr, lat, src, inv);
      pa = 1'b0; pb = 1'b0; pc = 1'b0; pd = 1'b0;
      for (int r = 0; r < 8; r++) begin
        for (int c = 0; c < 8; c++) begin
          logic a, b, cc, d, eh, el, fh, fl;
          string tag;
          a = PAT[r][24+c]; b = PAT[r][16+c]; cc = PAT[r][8+c]; d = PAT[r][c];
          cycle(a, b, cc, d, dh, dl, th, tl);
          if (ddr) begin
            eh = pa; el = pb; fh = pc; fl = pd;
          end else begin
            eh = a; el = a; fh = cc; fl = cc;
          end
          tag = ddr ? "R4" : (lat ? "R3" : "R2");
          tag = {tag, " R6"};
          if (inv) tag = {tag, " R7"};
          if (ddr && r == 0 && c == 0) tag = {tag, " R9"};
          check(tag, $sformatf("dat_out high cfg=%0d", cf), dh, eh);
          check(tag, $sformatf("dat_out low cfg=%0d", cf), dl, el);
          check({"R5 ", tag}, $sformatf("hiz_out high cfg=%0d", cf), th, fh);
          check({"R5 ", tag}, $sformatf("hiz_out low cfg=%0d", cf), tl, fl);
          pa = a; pb = b; pc = cc; pd = d;
        end
      end
    end

    // ---------------- R3 / R2: mid-phase input change ----------------
    for (int m = 0; m < 2; m++) begin
      logic lat;
      lat = (m == 1);
      setup(1'b0, lat, 2'd1, 1'b0);
      cycle(1'b0, 1'b0, 1'b0, 1'b0, dh, dl, th, tl);
      @(posedge eff);
      #2;  dat_rise = 1'b1; hiz_rise = 1'b1;
      #3;
      check(lat ? "R3" : "R2", "dat_out after high-phase change", dat_out, lat);
      check(lat ? "R5 R3" : "R5 R2", "hiz_out after high-phase change", hiz_out, lat);
      #7;  dat_rise = 1'b0; hiz_rise = 1'b0;
      #3;
      check(lat ? "R3" : "R2", "dat_out after low-phase change", dat_out, lat);
      check(lat ? "R5 R3" : "R5 R2", "hiz_out after low-phase change", hiz_out, lat);
      #1;
    end

    // ---------------- R8: configuration pins ignored while running ----------------
    begin
      logic pa, pb;
      setup(1'b1, 1'b0, 2'd0, 1'b0);
      pa = 1'b0; pb = 1'b0;
      for (int c = 0; c < 12; c++) begin
        logic a, b;
        if (c == 3) begin
          cfg_ddr = 1'b0; cfg_latch = 1'b1; cfg_src = 2'd2; cfg_inv = 1'b1;
        end
        a = c[0]; b = ~c[1];
        cycle(a, b, ~a, ~b, dh, dl, th, tl);
        if (c >= 4) begin
          check("R8", "dat_out high after cfg pin change", dh, pa);
          check("R8", "dat_out low after cfg pin change", dl, pb);
        end
        pa = a; pb = b;
      end
    end

    // ---------------- R1: reset in mid stream ----------------
    setup(1'b1, 1'b0, 2'd3, 1'b1);
    for (int c = 0; c < 4; c++) cycle(1'b1, 1'b1, 1'b1, 1'b1, dh, dl, th, tl);
    rst = 1'b1;
    cycle(1'b1, 1'b1, 1'b1, 1'b1, dh, dl, th, tl);
    check("R1", "dat_out high after mid-stream reset", dh, 1'b0);
    check("R1", "dat_out low after mid-stream reset", dl, 1'b0);
    check("R1", "hiz_out high after mid-stream reset", th, 1'b0);
    check("R1", "hiz_out low after mid-stream reset", tl, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule